// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Selectable Write Policy

This block sits between a processor that issues single-byte loads and stores on a 32-bit byte address and a backing memory that moves one 32-bit word per handshake. It holds 16 KB of data as 1024 lines of 16 bytes. Each request is looked up in exactly one line, chosen by the middle bits of the address. A hit answers in one cycle. A miss stalls the processor while the full line is brought in, four words in ascending order.

A parameter selects the write policy. With write-through, a store hit updates the cached byte and also writes the memory word, and a store miss goes straight to memory without allocating a line. With write-back, stores only touch the cache and mark the line dirty. A dirty line is copied back to memory before it is replaced, and a store miss first fills the line and then merges the byte. A flush input walks every line, copies back each dirty one and leaves it clean and still valid. A one-cycle done pulse then ends the walk.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` is 1, `cpu_done` is 0, `mem_req` is 0, and the first access to any line misses.
- R2: Address bits 31:14 are the tag, 13:4 the line index and 3:0 the byte offset. A line fill reads memory word addresses {tag, index, k} for k = 0,1,2,3 in that order.
- R3: A request hits only when the indexed line is valid and its stored tag equals the address tag. A load hit raises `cpu_done` one cycle after acceptance with no memory transfer.
- R4: A load miss fills the line with four memory reads and then returns the byte selected by the offset. Byte lane j of the word at offset bits 3:2 is data bits 8j+7:8j, with j equal to offset bits 1:0.
- R5: A miss to an index that holds another tag replaces that line, so a later access to the old address misses again.
- R6: In write-through mode a store hit updates the cached byte and makes one memory write. That write has `mem_be` one-hot at offset bits 1:0 and the byte repeated on all four lanes. Other bytes of the memory word stay unchanged.
- R7: In write-through mode a store miss makes exactly one memory write and allocates nothing, so a later load of that line misses and reads the stored byte from memory. No line is ever dirty in this mode.
- R8: In write-back mode a store hit makes no memory transfer, and a later load of that byte returns the stored value.
- R9: In write-back mode a miss whose victim line is valid and dirty first writes the old line back as four word writes to {old tag, index, k} for k = 0..3 in order, then does the four fill reads.
- R10: In write-back mode a store miss allocates the line: it fills it, merges the byte and leaves the line dirty.
- R11: A pulse on `flush_start` while idle writes back every valid dirty line, clears the dirty bits, keeps the lines valid and ends with a one-cycle `flush_done` while idle. A second flush makes no transfers.
- R12: `mem_req` with its address, direction and write data stays stable until `mem_ack`, and a transfer completes in the cycle where both are high.
- R13: `cpu_ready` is low from the acceptance of a request that needs memory until the cycle in which `cpu_done` is high. `cpu_done` is only raised while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for a byte store, 0 for a byte load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Cache idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a memory write |
| mem_waddr | output | 30 | Memory word address |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write word |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| flush_start | input | 1 | Start a flush walk (idle only) |
| flush_done | output | 1 | One-cycle pulse at the end of a flush walk |

## Verification
The bench attacks the dirty-victim conflict. A cache that refilled before writing back would lose the stored byte, so the old address would reload stale data. One that wrote back with the new tag would put the byte at the wrong memory word. Store misses are checked in both policies: allocating under write-through shows up as a hit on the following load, and failing to merge under write-back returns the memory value. Flush is run twice to expose dirty bits that are never cleared. Extra transfers on the second walk, or invalidated lines that miss on the next load, reveal a wrong flush. Byte-lane positions are checked against neighbouring bytes of the memory word, which a wrong enable would corrupt.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_EVICT   = 3'd1,
        ST_REFILL  = 3'd2,
        ST_WTHRU   = 3'd3,
        ST_SCAN    = 3'd4,
        ST_FLUSHWB = 3'd5
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int NUM_LINES  = 1024,
    parameter int TAG_W      = 18,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             dirty_set,
    input  logic             dirty_clr
);

    logic [NUM_LINES-1:0] valid_d, valid_q;
    logic [NUM_LINES-1:0] dirty_d, dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_we) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = fill_dirty;
        end
        if (dirty_set) dirty_d[idx] = 1'b1;
        if (dirty_clr) dirty_d[idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) tag_q[idx] <= fill_tag;
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    // R7
    wt_never_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK == 1'b0) |-> (dirty_q == '0));

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int NUM_LINES  = 1024,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int WPL       = LINE_BYTES / 4,
    localparam int WSEL_W    = $clog2(WPL),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              we,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata
);

    logic [LINE_W-1:0]     line_q [NUM_LINES];
    logic [LINE_BYTES-1:0] lane_we;

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        assign lane_we[k] = we && (wsel == WSEL_W'(k / 4)) && be[k % 4];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LINE_BYTES; k++) begin
            if (lane_we[k]) line_q[idx][k*8 +: 8] <= wdata[(k % 4)*8 +: 8];
        end
    end

    assign rd_line = line_q[idx];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 1024,
    parameter bit WRITE_BACK = 1'b1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WPL       = LINE_BYTES / 4,
    localparam int WSEL_W    = $clog2(WPL),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int MADDR_W   = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_waddr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    input  logic               flush_start,
    output logic               flush_done,
    output logic [IDX_W-1:0]   arr_idx,
    input  logic [TAG_W-1:0]   tag_rd,
    input  logic               valid_rd,
    input  logic               dirty_rd,
    input  logic [LINE_W-1:0]  line_rd,
    output logic               fill_we,
    output logic [TAG_W-1:0]   fill_tag,
    output logic               fill_dirty,
    output logic               dirty_set,
    output logic               dirty_clr,
    output logic               dat_we,
    output logic [WSEL_W-1:0]  dat_wsel,
    output logic [3:0]         dat_be,
    output logic [31:0]        dat_wdata
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);
    localparam logic [IDX_W-1:0]  LAST_LINE = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        dmc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [7:0]        wdata;
        logic [WSEL_W-1:0] beat;
        logic [IDX_W-1:0]  fidx;
        logic              done;
        logic [7:0]        rdata;
        logic              fdone;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    logic [1:0]        a_lane;
    logic [3:0]        lane_oh;
    logic              hit;
    logic [31:0]       hit_word;
    logic [31:0]       beat_word;
    logic [31:0]       fill_word;

    always_comb begin
        lk_addr   = (r_q.state == ST_IDLE) ? cpu_addr : r_q.addr;
        a_tag     = lk_addr[ADDR_W-1 -: TAG_W];
        a_idx     = lk_addr[OFF_W +: IDX_W];
        a_wsel    = lk_addr[2 +: WSEL_W];
        a_lane    = lk_addr[1:0];
        lane_oh   = 4'b0001 << a_lane;
        hit       = valid_rd && (tag_rd == a_tag);
        hit_word  = line_rd[int'(a_wsel)*32 +: 32];
        beat_word = line_rd[int'(r_q.beat)*32 +: 32];
        fill_word = mem_rdata;
        if (r_q.we && (r_q.beat == a_wsel)) fill_word[int'(a_lane)*8 +: 8] = r_q.wdata;

        arr_idx = (r_q.state == ST_SCAN || r_q.state == ST_FLUSHWB) ? r_q.fidx : a_idx;

        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fdone = 1'b0;

        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_waddr  = '0;
        mem_be     = 4'h0;
        mem_wdata  = '0;
        fill_we    = 1'b0;
        fill_tag   = a_tag;
        fill_dirty = 1'b0;
        dirty_set  = 1'b0;
        dirty_clr  = 1'b0;
        dat_we     = 1'b0;
        dat_wsel   = a_wsel;
        dat_be     = 4'hF;
        dat_wdata  = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (flush_start) begin
                    r_d.fidx  = '0;
                    r_d.state = ST_SCAN;
                end else if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.beat  = '0;
                    if (hit) begin
                        if (!cpu_we) begin
                            r_d.done  = 1'b1;
                            r_d.rdata = hit_word[int'(a_lane)*8 +: 8];
                        end else begin
                            dat_we    = 1'b1;
                            dat_be    = lane_oh;
                            dat_wdata = {4{cpu_wdata}};
                            if (WRITE_BACK) begin
                                dirty_set = 1'b1;
                                r_d.done  = 1'b1;
                            end else begin
                                r_d.state = ST_WTHRU;
                            end
                        end
                    end else if (cpu_we && !WRITE_BACK) begin
                        r_d.state = ST_WTHRU;
                    end else if (WRITE_BACK && valid_rd && dirty_rd) begin
                        r_d.state = ST_EVICT;
                    end else begin
                        r_d.state = ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_waddr = {tag_rd, a_idx, r_q.beat};
                mem_wdata = beat_word;
                mem_be    = 4'hF;
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) r_d.state = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                mem_waddr = {a_tag, a_idx, r_q.beat};
                if (mem_ack) begin
                    dat_we    = 1'b1;
                    dat_wsel  = r_q.beat;
                    dat_wdata = fill_word;
                    if (!r_q.we && (r_q.beat == a_wsel))
                        r_d.rdata = mem_rdata[int'(a_lane)*8 +: 8];
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) begin
                        fill_we    = 1'b1;
                        fill_dirty = r_q.we;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_waddr = r_q.addr[ADDR_W-1:2];
                mem_be    = lane_oh;
                mem_wdata = {4{r_q.wdata}};
                if (mem_ack) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_SCAN: begin
                r_d.beat = '0;
                if (valid_rd && dirty_rd) begin
                    r_d.state = ST_FLUSHWB;
                end else if (r_q.fidx == LAST_LINE) begin
                    r_d.fdone = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.fidx = r_q.fidx + 1'b1;
                end
            end
            ST_FLUSHWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_waddr = {tag_rd, r_q.fidx, r_q.beat};
                mem_wdata = beat_word;
                mem_be    = 4'hF;
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) begin
                        dirty_clr = 1'b1;
                        if (r_q.fidx == LAST_LINE) begin
                            r_d.fdone = 1'b1;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.fidx  = r_q.fidx + 1'b1;
                            r_d.state = ST_SCAN;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_ready  = (r_q.state == ST_IDLE);
    assign cpu_done   = r_q.done;
    assign cpu_rdata  = r_q.rdata;
    assign flush_done = r_q.fdone;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_waddr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && (mem_waddr[WSEL_W-1:0] != LAST_BEAT))
        |=> (mem_req && !mem_we && (mem_waddr[WSEL_W-1:0] == $past(mem_waddr[WSEL_W-1:0]) + 1'b1)));

    // R9
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (r_q.state == ST_EVICT) && (mem_waddr[WSEL_W-1:0] == LAST_BEAT))
        |=> (mem_req && !mem_we && (mem_waddr[WSEL_W-1:0] == '0)));

    // R13
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_ready);

    // R11
    flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (cpu_ready && !mem_req));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 1024,
    parameter bit WRITE_BACK = 1'b1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WSEL_W    = $clog2(LINE_BYTES / 4),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int MADDR_W   = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_waddr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    input  logic               flush_start,
    output logic               flush_done
);

    logic [IDX_W-1:0]  arr_idx;
    logic [TAG_W-1:0]  tag_rd;
    logic              valid_rd;
    logic              dirty_rd;
    logic [LINE_W-1:0] line_rd;
    logic              fill_we;
    logic [TAG_W-1:0]  fill_tag;
    logic              fill_dirty;
    logic              dirty_set;
    logic              dirty_clr;
    logic              dat_we;
    logic [WSEL_W-1:0] dat_wsel;
    logic [3:0]        dat_be;
    logic [31:0]       dat_wdata;

    dmc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .WRITE_BACK(WRITE_BACK)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (arr_idx),
        .rd_tag    (tag_rd),
        .rd_valid  (valid_rd),
        .rd_dirty  (dirty_rd),
        .fill_we   (fill_we),
        .fill_tag  (fill_tag),
        .fill_dirty(fill_dirty),
        .dirty_set (dirty_set),
        .dirty_clr (dirty_clr)
    );

    dmc_line_store #(
        .NUM_LINES (NUM_LINES),
        .LINE_BYTES(LINE_BYTES)
    ) u_lines (
        .clk    (clk),
        .idx    (arr_idx),
        .rd_line(line_rd),
        .we     (dat_we),
        .wsel   (dat_wsel),
        .be     (dat_be),
        .wdata  (dat_wdata)
    );

    dmc_ctrl #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .NUM_LINES (NUM_LINES),
        .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .flush_start(flush_start),
        .flush_done (flush_done),
        .arr_idx    (arr_idx),
        .tag_rd     (tag_rd),
        .valid_rd   (valid_rd),
        .dirty_rd   (dirty_rd),
        .line_rd    (line_rd),
        .fill_we    (fill_we),
        .fill_tag   (fill_tag),
        .fill_dirty (fill_dirty),
        .dirty_set  (dirty_set),
        .dirty_clr  (dirty_clr),
        .dat_we     (dat_we),
        .dat_wsel   (dat_wsel),
        .dat_be     (dat_be),
        .dat_wdata  (dat_wdata)
    );

endmodule

// File: tb/tb_dmc_cache.sv
`timescale 1ns/1ps

module tb_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [29:0] waddr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic [31:0] rdata
);
    logic [31:0] mem [256];
    logic        lg_we [64];
    logic [29:0] lg_addr [64];
    int          lg_n;
    int          proto_err;
    logic        pend_q;
    logic [29:0] pend_addr_q;

    function automatic logic [7:0] slot(input logic [29:0] w);
        return {w[13:12], w[5:2], w[1:0]};
    endfunction

    function automatic logic [31:0] seed_word(input logic [7:0] i);
        return {i ^ 8'hA5, i, ~i, i + 8'h3C};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = seed_word(8'(i));
        lg_n = 0;
        proto_err = 0;
    end

    assign rdata = mem[slot(waddr)];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (pend_q && (!req || waddr != pend_addr_q)) proto_err <= proto_err + 1;
            pend_q      <= req && !ack;
            pend_addr_q <= waddr;
            if (req && ack) begin
                if (we) begin
                    for (int b = 0; b < 4; b++)
                        if (be[b]) mem[slot(waddr)][b*8 +: 8] <= wdata[b*8 +: 8];
                end
                lg_we[lg_n % 64]   <= we;
                lg_addr[lg_n % 64] <= waddr;
                lg_n <= lg_n + 1;
                ack  <= 1'b0;
            end else begin
                ack <= req;
            end
        end
    end
endmodule

module tb_dmc_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // index 0: write-through instance, index 1: write-back instance
    logic        c_req [2];
    logic        c_we [2];
    logic [31:0] c_addr [2];
    logic [7:0]  c_wd [2];
    logic        c_ready [2];
    logic        c_done [2];
    logic [7:0]  c_rd [2];
    logic        f_start [2];
    logic        f_done [2];
    logic        m_req [2];
    logic        m_we [2];
    logic [29:0] m_addr [2];
    logic [3:0]  m_be [2];
    logic [31:0] m_wd [2];
    logic        m_ack [2];
    logic [31:0] m_rd [2];

    int n_chk = 0;
    int n_fail = 0;

    dmc_cache #(.WRITE_BACK(1'b0)) dut_wt (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_wdata(c_wd[0]),
        .cpu_ready(c_ready[0]), .cpu_done(c_done[0]), .cpu_rdata(c_rd[0]),
        .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_waddr(m_addr[0]), .mem_be(m_be[0]),
        .mem_wdata(m_wd[0]), .mem_ack(m_ack[0]), .mem_rdata(m_rd[0]),
        .flush_start(f_start[0]), .flush_done(f_done[0]));

    dmc_cache #(.WRITE_BACK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_wdata(c_wd[1]),
        .cpu_ready(c_ready[1]), .cpu_done(c_done[1]), .cpu_rdata(c_rd[1]),
        .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_waddr(m_addr[1]), .mem_be(m_be[1]),
        .mem_wdata(m_wd[1]), .mem_ack(m_ack[1]), .mem_rdata(m_rd[1]),
        .flush_start(f_start[1]), .flush_done(f_done[1]));

    tb_mem_model mdl_wt (.clk(clk), .rst_n(rst_n), .req(m_req[0]), .we(m_we[0]), .waddr(m_addr[0]),
        .be(m_be[0]), .wdata(m_wd[0]), .ack(m_ack[0]), .rdata(m_rd[0]));
    tb_mem_model mdl_wb (.clk(clk), .rst_n(rst_n), .req(m_req[1]), .we(m_we[1]), .waddr(m_addr[1]),
        .be(m_be[1]), .wdata(m_wd[1]), .ack(m_ack[1]), .rdata(m_rd[1]));

    function automatic logic [7:0] seed_byte(input logic [31:0] a);
        logic [7:0]  i = {a[15:14], a[7:4], a[3:2]};
        logic [31:0] w = {i ^ 8'hA5, i, ~i, i + 8'h3C};
        return w[int'(a[1:0])*8 +: 8];
    endfunction

    function automatic int log_count(input int m);
        return (m == 0) ? mdl_wt.lg_n : mdl_wb.lg_n;
    endfunction

    function automatic logic [30:0] log_entry(input int m, input int k);
        if (m == 0) return {mdl_wt.lg_we[k % 64], mdl_wt.lg_addr[k % 64]};
        return {mdl_wb.lg_we[k % 64], mdl_wb.lg_addr[k % 64]};
    endfunction

    function automatic logic [7:0] model_byte(input int m, input logic [31:0] a);
        logic [7:0] s = {a[15:14], a[7:4], a[3:2]};
        logic [31:0] w = (m == 0) ? mdl_wt.mem[s] : mdl_wb.mem[s];
        return w[int'(a[1:0])*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic access(input int m, input bit we, input logic [31:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int lat, output int xf, output bit rdy_bad);
        int n0;
        int guard = 0;
        @(negedge clk);
        while (!c_ready[m] && guard < 5000) begin @(negedge clk); guard++; end
        n0 = log_count(m);
        c_req[m] = 1'b1; c_we[m] = we; c_addr[m] = a; c_wd[m] = wd;
        @(negedge clk);
        c_req[m] = 1'b0;
        lat = 1;
        rdy_bad = 1'b0;
        while (!c_done[m] && lat < 100) begin
            if (c_ready[m]) rdy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (!c_ready[m]) rdy_bad = 1'b1;
        rd = c_rd[m];
        xf = log_count(m) - n0;
    endtask

    task automatic flush(input int m, output int xf, output int cyc, output int n0);
        @(negedge clk);
        n0 = log_count(m);
        f_start[m] = 1'b1;
        @(negedge clk);
        f_start[m] = 1'b0;
        cyc = 1;
        while (!f_done[m] && cyc < 5000) begin @(negedge clk); cyc++; end
        xf = log_count(m) - n0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [7:0]  wd;
        logic [1:0]  kind;   // 0 seed byte, 1 literal, 2 no data check
        logic [7:0]  lit;
        logic [3:0]  xf;
        logic [17:0] vtag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0014, 8'h00, 2'd0, 8'h00, 4'd4, 18'd0},
        '{1'b0, 32'h0000_001C, 8'h00, 2'd0, 8'h00, 4'd0, 18'd0},
        '{1'b0, 32'h0000_0034, 8'h00, 2'd0, 8'h00, 4'd4, 18'd0},
        '{1'b1, 32'h0000_0015, 8'h77, 2'd2, 8'h00, 4'd0, 18'd0},
        '{1'b0, 32'h0000_0015, 8'h00, 2'd1, 8'h77, 4'd0, 18'd0},
        '{1'b0, 32'h0000_8014, 8'h00, 2'd0, 8'h00, 4'd8, 18'd0},
        '{1'b0, 32'h0000_0015, 8'h00, 2'd1, 8'h77, 4'd4, 18'd0},
        '{1'b1, 32'h0000_402E, 8'h9C, 2'd2, 8'h00, 4'd4, 18'd0},
        '{1'b0, 32'h0000_402E, 8'h00, 2'd1, 8'h9C, 4'd0, 18'd0},
        '{1'b0, 32'h0000_4020, 8'h00, 2'd0, 8'h00, 4'd0, 18'd0},
        '{1'b1, 32'h0000_0037, 8'h12, 2'd2, 8'h00, 4'd0, 18'd0}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int lat, xf, cyc, n0, base;
        bit rb;
        logic [30:0] e;
        logic [29:0] line_w;
        for (int m = 0; m < 2; m++) begin
            c_req[m] = 1'b0; c_we[m] = 1'b0; c_addr[m] = '0; c_wd[m] = '0; f_start[m] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int m = 0; m < 2; m++) begin
            chk(c_ready[m] == 1'b1, "R1 ready after reset", 32'(c_ready[m]), 1);
            chk(c_done[m] == 1'b0, "R1 done after reset", 32'(c_done[m]), 0);
            chk(m_req[m] == 1'b0, "R1 mem idle after reset", 32'(m_req[m]), 0);
        end

        // write-back table
        for (int v = 0; v < NV; v++) begin
            access(1, VECS[v].we, VECS[v].addr, VECS[v].wd, rd, lat, xf, rb);
            base = log_count(1) - xf;
            line_w = VECS[v].addr[31:4] << 2;
            if (VECS[v].kind == 2'd0) chk(rd == seed_byte(VECS[v].addr), "R4 load byte", rd, seed_byte(VECS[v].addr));
            if (VECS[v].kind == 2'd1) chk(rd == VECS[v].lit, "R8 R10 R5 load byte", rd, VECS[v].lit);
            chk(xf == int'(VECS[v].xf), "R1 R3 R9 transfer count", xf, VECS[v].xf);
            if (xf == 0) chk(lat == 1, "R3 hit latency", lat, 1);
            else         chk(!rb, "R13 ready low during miss", 32'(rb), 0);
            if (VECS[v].xf >= 4 && xf >= 4) begin
                for (int k = 0; k < 4; k++) begin
                    e = log_entry(1, base + xf - 4 + k);
                    chk(e == {1'b0, line_w | 30'(k)}, "R2 fill read order", e, {1'b0, line_w | 30'(k)});
                end
            end
            if (VECS[v].xf == 8 && xf == 8) begin
                for (int k = 0; k < 4; k++) begin
                    e = log_entry(1, base + k);
                    chk(e == {1'b1, VECS[v].vtag, VECS[v].addr[13:4], 2'(k)}, "R9 writeback order",
                        e, {1'b1, VECS[v].vtag, VECS[v].addr[13:4], 2'(k)});
                end
                chk(model_byte(1, 32'h15) == 8'h77, "R9 victim byte in memory", model_byte(1, 32'h15), 8'h77);
            end
        end

        // R6 R7 write-through instance
        access(0, 1'b0, 32'h48, 8'h00, rd, lat, xf, rb);
        chk(xf == 4 && rd == seed_byte(32'h48), "R4 WT load miss", {xf[7:0], rd}, {8'd4, seed_byte(32'h48)});
        access(0, 1'b1, 32'h49, 8'h3E, rd, lat, xf, rb);
        chk(xf == 1, "R6 store hit one write", xf, 1);
        e = log_entry(0, log_count(0) - 1);
        chk(e == {1'b1, 30'h12}, "R6 write address", e, {1'b1, 30'h12});
        chk(model_byte(0, 32'h49) == 8'h3E, "R6 memory byte", model_byte(0, 32'h49), 8'h3E);
        chk(model_byte(0, 32'h48) == seed_byte(32'h48), "R6 neighbour lane kept", model_byte(0, 32'h48), seed_byte(32'h48));
        chk(model_byte(0, 32'h4A) == seed_byte(32'h4A), "R6 neighbour lane kept", model_byte(0, 32'h4A), seed_byte(32'h4A));
        access(0, 1'b0, 32'h49, 8'h00, rd, lat, xf, rb);
        chk(xf == 0 && rd == 8'h3E, "R6 cache byte updated", {xf[7:0], rd}, {8'd0, 8'h3E});
        access(0, 1'b1, 32'h52, 8'h41, rd, lat, xf, rb);
        chk(xf == 1, "R7 store miss one write", xf, 1);
        access(0, 1'b0, 32'h52, 8'h00, rd, lat, xf, rb);
        chk(xf == 4, "R7 no allocate", xf, 4);
        chk(rd == 8'h41, "R7 byte from memory", rd, 8'h41);
        flush(0, xf, cyc, n0);
        chk(xf == 0 && cyc < 5000, "R7 R11 WT flush no writes", xf, 0);

        // R11 write-back flush
        flush(1, xf, cyc, n0);
        chk(cyc < 5000, "R11 flush done seen", cyc, 0);
        chk(xf == 8, "R11 flush writes", xf, 8);
        e = log_entry(1, n0);
        chk(e == {1'b1, 30'h1008}, "R11 first flushed line", e, {1'b1, 30'h1008});
        e = log_entry(1, n0 + 4);
        chk(e == {1'b1, 30'h000C}, "R11 second flushed line", e, {1'b1, 30'h000C});
        chk(model_byte(1, 32'h402E) == 8'h9C, "R10 R11 merged byte written back", model_byte(1, 32'h402E), 8'h9C);
        chk(model_byte(1, 32'h37) == 8'h12, "R11 store byte written back", model_byte(1, 32'h37), 8'h12);
        flush(1, xf, cyc, n0);
        chk(xf == 0 && cyc < 5000, "R11 second flush idle", xf, 0);
        access(1, 1'b0, 32'h37, 8'h00, rd, lat, xf, rb);
        chk(xf == 0 && rd == 8'h12, "R11 line still valid", {xf[7:0], rd}, {8'd0, 8'h12});
        access(1, 1'b0, 32'h4037, 8'h00, rd, lat, xf, rb);
        chk(xf == 4, "R11 R9 clean victim no writeback", xf, 4);
        chk(rd == seed_byte(32'h4037), "R5 conflict load byte", rd, seed_byte(32'h4037));

        // R12 handshake stability seen by both memories
        chk(mdl_wt.proto_err == 0, "R12 WT handshake", mdl_wt.proto_err, 0);
        chk(mdl_wb.proto_err == 0, "R12 WB handshake", mdl_wb.proto_err, 0);

        summary();
        $finish;
    end
endmodule